// File: doc/BRIEF.md
# Iterative Slice-Serial Magnitude Comparator

This block orders two equal-width operands by subtracting one from the other a few bits at a time instead of in a single wide step. An operand pair is taken over a valid/ready input port. The block then walks from the least significant slice upward, one slice per enabled clock, and carries the borrow and a running "all slices equal" flag from one slice to the next. When the top slice is done it returns nine relational flags on a valid/ready output port: equality, and less/less-or-equal/greater/greater-or-equal in both unsigned and two's-complement readings. An optional run of extra register stages can be placed between the final flag logic and the output, to relieve timing.

The signed ordering is computed from explicit bit logic and never from signed declarations. When the operand signs differ, the operand whose sign bit is set is the smaller one. When the signs match, the unsigned ordering applies. Only one operation is in flight at a time. Back-pressure is simple. `in_ready` is high only when the block is idle, and it stays low from the accepting edge until the result has been taken. `out_valid` and the flags hold steady for as long as `out_ready` is low. `clk_en` low freezes every register, including both handshakes.

Top module: `cmp_iter_compare`

## Requirements
- R1: After `clear` is held high across a rising edge, `in_ready` is 1 and `out_valid` is 0.
- R2: A pair is accepted on an enabled edge where `in_valid` and `in_ready` are both high. `in_ready` then stays 0 until the enabled edge where `out_valid` and `out_ready` are both high, and `in_valid` or operand changes in that window do not affect the result.
- R3: `out_valid` rises exactly NSLICE + EXTRA_STAGES enabled edges after the accepting edge, where NSLICE = ceil(DATA_W / SLICE_W).
- R4: `eq` is 1 exactly when `opa` equals `opb` in every bit.
- R5: `ult` is 1 exactly when `opa` < `opb` as unsigned numbers, `ugt` exactly when `opa` > `opb`, and exactly one of `ult`, `eq`, `ugt` is high while `out_valid` is 1.
- R6: `slt` is 1 exactly when `opa` < `opb` read as two's-complement numbers (bit DATA_W-1 is the sign), `sgt` exactly when `opa` > `opb`, and exactly one of `slt`, `eq`, `sgt` is high while `out_valid` is 1.
- R7: `ule` = `ult` | `eq`, `uge` = `ugt` | `eq`, `sle` = `slt` | `eq`, `sge` = `sgt` | `eq`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all nine flags keep their values.
- R9: On a rising edge with `clk_en` low, no state changes: `in_ready` and `out_valid` keep their values and no handshake completes.
- R10: When DATA_W is not a multiple of SLICE_W, the top slice covers only the remaining bits and all flags are still correct, including for operands whose sign bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clk_en | input | 1 | Clock enable for all state |
| clear | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block is idle and will take a pair |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| out_valid | output | 1 | Flags are valid |
| out_ready | input | 1 | Consumer takes the flags |
| eq | output | 1 | opa == opb |
| ult | output | 1 | opa < opb, unsigned |
| ule | output | 1 | opa <= opb, unsigned |
| ugt | output | 1 | opa > opb, unsigned |
| uge | output | 1 | opa >= opb, unsigned |
| slt | output | 1 | opa < opb, signed |
| sle | output | 1 | opa <= opb, signed |
| sgt | output | 1 | opa > opb, signed |
| sge | output | 1 | opa >= opb, signed |

## Verification
The embedded properties watch every cycle for the following: the exact trichotomy of each flag family, held outputs under back-pressure, frozen handshakes while the enable is low, `in_ready` and `out_valid` never both high, and the exact enabled-cycle latency, which an internal counter measures. Whether the flags are numerically right for a given pair can only be shown by the bench. The bench drives directed pairs with known answers: borrows that ripple across every slice, sign-bit and most-negative cases, a narrow top slice, and operands changed while the block is busy.

// File: rtl/cmp_iter_pkg.sv
package cmp_iter_pkg;

  typedef struct packed {
    logic eq;
    logic ult;
    logic ule;
    logic ugt;
    logic uge;
    logic slt;
    logic sle;
    logic sgt;
    logic sge;
  } cmp_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } cmp_state_t;

endpackage

// File: rtl/cmp_slice_sub.sv
module cmp_slice_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic         cout,
  output logic         zero
);
  logic [W:0] diff;

  // a - b as a + ~b + cin; carry out high means no borrow
  assign diff = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
  assign cout = diff[W];
  assign zero = (diff[W-1:0] == '0);
endmodule

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen
  import cmp_iter_pkg::*;
(
  input  logic       all_zero,
  input  logic       no_borrow,
  input  logic       a_sign,
  input  logic       b_sign,
  output cmp_flags_t flags
);
  logic u_lt, s_lt;

  always_comb begin
    u_lt = ~no_borrow;
    // signs differ: the negative one is smaller; signs equal: unsigned order
    s_lt = (a_sign ^ b_sign) ? a_sign : u_lt;
    flags.eq  = all_zero;
    flags.ult = u_lt;
    flags.ule = u_lt | all_zero;
    flags.ugt = ~(u_lt | all_zero);
    flags.uge = ~u_lt;
    flags.slt = s_lt;
    flags.sle = s_lt | all_zero;
    flags.sgt = ~(s_lt | all_zero);
    flags.sge = ~s_lt;
  end
endmodule

// File: rtl/cmp_delay.sv
module cmp_delay #(
  parameter int DEPTH = 0,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         en,
  input  logic         clear,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign v_out = v_in;
      assign d_out = d_in;
    end else begin : g_regs
      logic [DEPTH-1:0] v_q;
      logic [W-1:0]     d_q [DEPTH];
      always_ff @(posedge clk) begin
        if (clear) begin
          v_q <= '0;
        end else if (en) begin
          v_q[0] <= v_in;
          for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
        end
      end
      always_ff @(posedge clk) begin
        if (en) begin
          d_q[0] <= d_in;
          for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
        end
      end
      assign v_out = v_q[DEPTH-1];
      assign d_out = d_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/cmp_iter_compare.sv
module cmp_iter_compare
  import cmp_iter_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SLICE_W      = 8,
  parameter int EXTRA_STAGES = 0
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              eq,
  output logic              ult,
  output logic              ule,
  output logic              ugt,
  output logic              uge,
  output logic              slt,
  output logic              sle,
  output logic              sgt,
  output logic              sge
);
  localparam int NSLICE  = (DATA_W + SLICE_W - 1) / SLICE_W;
  localparam int LAST_W  = DATA_W - (NSLICE - 1) * SLICE_W;
  localparam int IDX_W   = (NSLICE > 1) ? $clog2(NSLICE) : 1;
  localparam int FLAG_W  = $bits(cmp_flags_t);
  localparam int LATENCY = NSLICE + EXTRA_STAGES;

  cmp_state_t        state_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [IDX_W-1:0]  idx_q;
  logic              carry_q;
  logic              zacc_q;
  logic              a_sign_q, b_sign_q;
  logic              accept, take, last;

  logic [SLICE_W-1:0] a_sl, b_sl;
  logic               sl_cout, sl_zero;
  cmp_flags_t         fin_flags, pipe_flags, out_q;
  logic               pipe_v;
  logic [FLAG_W-1:0]  pipe_bits;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = clk_en & in_valid & in_ready;
  assign take     = clk_en & out_valid & out_ready;
  assign last     = (idx_q == IDX_W'(NSLICE - 1));

  // current slice sits at the bottom of the shifting operand registers
  generate
    if (LAST_W == SLICE_W) begin : g_even
      assign a_sl = a_q[SLICE_W-1:0];
      assign b_sl = b_q[SLICE_W-1:0];
    end else begin : g_short_top
      assign a_sl = last ? {{(SLICE_W-LAST_W){1'b0}}, a_q[LAST_W-1:0]} : a_q[SLICE_W-1:0];
      assign b_sl = last ? {{(SLICE_W-LAST_W){1'b0}}, b_q[LAST_W-1:0]} : b_q[SLICE_W-1:0];
    end
  endgenerate

  cmp_slice_sub #(.W(SLICE_W)) u_slice (
    .a    (a_sl),
    .b    (b_sl),
    .cin  (carry_q),
    .cout (sl_cout),
    .zero (sl_zero)
  );

  cmp_flag_gen u_flags (
    .all_zero  (zacc_q & sl_zero),
    .no_borrow (sl_cout),
    .a_sign    (a_sign_q),
    .b_sign    (b_sign_q),
    .flags     (fin_flags)
  );

  cmp_delay #(.DEPTH(EXTRA_STAGES), .W(FLAG_W)) u_pipe (
    .clk   (clk),
    .en    (clk_en),
    .clear (clear),
    .v_in  ((state_q == ST_SCAN) && last),
    .d_in  (fin_flags),
    .v_out (pipe_v),
    .d_out (pipe_bits)
  );
  assign pipe_flags = cmp_flags_t'(pipe_bits);

  always_ff @(posedge clk) begin
    if (clear) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      carry_q   <= 1'b1;
      zacc_q    <= 1'b1;
      out_valid <= 1'b0;
    end else if (clk_en) begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
          carry_q <= 1'b1;
          zacc_q  <= 1'b1;
        end
        ST_SCAN: begin
          carry_q <= sl_cout;
          zacc_q  <= zacc_q & sl_zero;
          idx_q   <= idx_q + 1'b1;
          if (last) state_q <= ST_DRAIN;
        end
        ST_DRAIN: if (out_valid && out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      if (pipe_v)           out_valid <= 1'b1;
      else if (out_ready)   out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q      <= opa;
      b_q      <= opb;
      a_sign_q <= opa[DATA_W-1];
      b_sign_q <= opb[DATA_W-1];
    end else if (clk_en && state_q == ST_SCAN) begin
      a_q <= a_q >> SLICE_W;
      b_q <= b_q >> SLICE_W;
    end
    if (clk_en && pipe_v) out_q <= pipe_flags;
  end

  assign eq  = out_q.eq;
  assign ult = out_q.ult;
  assign ule = out_q.ule;
  assign ugt = out_q.ugt;
  assign uge = out_q.uge;
  assign slt = out_q.slt;
  assign sle = out_q.sle;
  assign sgt = out_q.sgt;
  assign sge = out_q.sge;

  // enabled cycles since acceptance, for the latency property only
  logic [15:0] lat_q;
  always_ff @(posedge clk) begin
    if (clear)                                  lat_q <= '0;
    else if (accept)                            lat_q <= '0;
    else if (clk_en && !out_valid && !in_ready) lat_q <= lat_q + 1'b1;
  end

  AST_CLEAR_IDLE: assert property (@(posedge clk) $fell(clear) |-> in_ready && !out_valid); // R1
  AST_NO_DUAL_READY: assert property (@(posedge clk) disable iff (clear) !(in_ready && out_valid)); // R2
  AST_BUSY_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (clear) (!in_ready && !take) |=> !in_ready); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (clear) $rose(out_valid) |-> lat_q == 16'(LATENCY)); // R3
  AST_U_TRICHOTOMY: assert property (@(posedge clk) disable iff (clear) out_valid |-> $countones({ult, eq, ugt}) == 1); // R5
  AST_S_TRICHOTOMY: assert property (@(posedge clk) disable iff (clear) out_valid |-> $countones({slt, eq, sgt}) == 1); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (clear) (out_valid && !out_ready) |=> out_valid && $stable({eq, ult, ule, ugt, uge, slt, sle, sgt, sge})); // R8
  AST_FREEZE: assert property (@(posedge clk) disable iff (clear) !clk_en |=> $stable({in_ready, out_valid})); // R9
endmodule

// File: tb/cmp_iter_compare_tb_top.sv
module cmp_iter_compare_tb_top;
  logic clk = 1'b0;
  logic clk_en = 1'b1;
  logic clear = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // main instance: 32 bits, 8-bit slices, no extra stages
  logic        iv0 = 0, or0 = 0;
  logic [31:0] a0 = '0, b0 = '0;
  logic        ir0, ov0;
  logic [8:0]  f0;
  // narrow-top instance: 20 bits, 8-bit slices, two extra stages
  logic        iv1 = 0, or1 = 0;
  logic [19:0] a1 = '0, b1 = '0;
  logic        ir1, ov1;
  logic [8:0]  f1;

  cmp_iter_compare #(.DATA_W(32), .SLICE_W(8), .EXTRA_STAGES(0)) dut_i (
    .clk(clk), .clk_en(clk_en), .clear(clear),
    .in_valid(iv0), .in_ready(ir0), .opa(a0), .opb(b0),
    .out_valid(ov0), .out_ready(or0),
    .eq(f0[8]), .ult(f0[7]), .ule(f0[6]), .ugt(f0[5]), .uge(f0[4]),
    .slt(f0[3]), .sle(f0[2]), .sgt(f0[1]), .sge(f0[0]));

  cmp_iter_compare #(.DATA_W(20), .SLICE_W(8), .EXTRA_STAGES(2)) dut_odd_i (
    .clk(clk), .clk_en(clk_en), .clear(clear),
    .in_valid(iv1), .in_ready(ir1), .opa(a1), .opb(b1),
    .out_valid(ov1), .out_ready(or1),
    .eq(f1[8]), .ult(f1[7]), .ule(f1[6]), .ugt(f1[5]), .uge(f1[4]),
    .slt(f1[3]), .sle(f1[2]), .sgt(f1[1]), .sge(f1[0]));

  bit sel = 1'b0;
  logic       v_ir, v_ov;
  logic [8:0] v_f;
  always_comb begin
    v_ir = sel ? ir1 : ir0;
    v_ov = sel ? ov1 : ov0;
    v_f  = sel ? f1  : f0;
  end

  task automatic check(string req, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // flag order {eq, ult, ule, ugt, uge, slt, sle, sgt, sge}
  function automatic logic [8:0] ref_flags(longint a, longint b, int w);
    longint m  = (longint'(1) << w) - 1;
    longint ua = a & m, ub = b & m;
    longint sa = ((ua >> (w - 1)) & 1) != 0 ? ua - (m + 1) : ua;
    longint sb = ((ub >> (w - 1)) & 1) != 0 ? ub - (m + 1) : ub;
    logic e = (ua == ub);
    logic ul = (ua < ub), sl = (sa < sb);
    return {e, ul, ul | e, ~(ul | e), ~ul, sl, sl | e, ~(sl | e), ~sl};
  endfunction

  task automatic drive(bit s, logic v, longint a, longint b);
    if (s) begin iv1 = v; a1 = a[19:0]; b1 = b[19:0]; end
    else   begin iv0 = v; a0 = a[31:0]; b0 = b[31:0]; end
  endtask

  task automatic set_ready(bit s, logic r);
    if (s) or1 = r; else or0 = r;
  endtask

  // one operation; hold = back-pressure cycles, stall = enable-low cycles, poke = busy-time input
  task automatic run_op(string req, bit s, longint a, longint b, int hold, int stall, bit poke);
    int w   = s ? 20 : 32;
    int lat = s ? 5 : 4;
    int n;
    logic [8:0] exp = ref_flags(a, b, w);
    logic [8:0] held;
    sel = s;
    @(negedge clk);
    drive(s, 1'b1, a, b);
    check("R2", "in_ready before accept", v_ir, 1);
    @(negedge clk);
    if (poke) drive(s, 1'b1, ~a, a ^ 5);
    else      drive(s, 1'b0, 0, 0);
    if (stall > 0) begin
      clk_en = 1'b0;
      for (int i = 0; i < stall; i++) begin
        check("R9", "out_valid frozen", v_ov, 0);
        check("R9", "in_ready frozen", v_ir, 0);
        @(negedge clk);
      end
      clk_en = 1'b1;
    end
    n = 0;
    while (!v_ov && n < 64) begin
      if (v_ir) begin
        checks++; errors++;
        $display("FAIL R2 in_ready high while busy: got 1 expected 0");
      end
      @(negedge clk);
      n++;
    end
    check("R3", "latency", n, lat);
    check("R4 R5 R6 R7", "flags", v_f, exp);
    held = v_f;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8", "valid held", v_ov, 1);
      check("R8", "flags held", v_f, held);
    end
    drive(s, 1'b0, 0, 0);
    set_ready(s, 1'b1);
    @(negedge clk);
    set_ready(s, 1'b0);
    check("R2", "out_valid after take", v_ov, 0);
    check("R2", "in_ready after take", v_ir, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    clear = 1'b0;
    @(negedge clk);
    check("R1", "in_ready", ir0, 1);
    check("R1", "out_valid", ov0, 0);
    check("R1", "in_ready narrow", ir1, 1);
    check("R1", "out_valid narrow", ov1, 0);
  endtask

  task automatic t_unsigned_patterns();
    run_op("R4", 0, 32'h1234_5678, 32'h1234_5678, 0, 0, 0);
    run_op("R5", 0, 5, 3, 0, 0, 0);
    run_op("R5", 0, 3, 5, 0, 0, 0);
    run_op("R5", 0, 32'h1234_5678, 32'h1234_5679, 0, 0, 0);
    run_op("R5", 0, 32'h0100_0000, 32'h00FF_FFFF, 0, 0, 0);
    run_op("R4", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_signed_edges();
    run_op("R6", 0, 32'h8000_0000, 1, 0, 0, 0);
    run_op("R6", 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    run_op("R6", 0, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0);
    run_op("R6", 0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    run_op("R8", 0, 32'hA5A5_0000, 32'h5A5A_FFFF, 4, 0, 0);
  endtask

  task automatic t_busy_ignore();
    run_op("R2", 0, 32'h0000_0010, 32'h0000_0020, 1, 0, 1);
  endtask

  task automatic t_enable_freeze();
    run_op("R9", 0, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 0, 5, 0);
  endtask

  task automatic t_narrow_top();
    run_op("R10", 1, 20'h80000, 20'h7FFFF, 0, 0, 0);
    run_op("R10", 1, 20'hFFFFF, 20'hFFFFF, 2, 0, 0);
    run_op("R10", 1, 20'h00001, 20'hFFFFF, 0, 0, 0);
    run_op("R10", 1, 20'h3_0000, 20'h2_FFFF, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_unsigned_patterns();
    t_signed_edges();
    t_backpressure();
    t_busy_ignore();
    t_enable_freeze();
    t_narrow_top();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule